// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a parameterized set of sources and presents one interrupt line to a single processor. Each source owns a configuration word with a mask, a read-only activity flag, an active polarity, an edge-or-level sense choice, a 4-bit priority and an 8-bit vector. The processor programs and reads the block through a simple 32-bit register port with separate read and write strobes. It serves an interrupt by reading an acknowledge register, which returns the vector of the winning source and places that source in service. It ends service by writing any value to an end-of-interrupt register.

Delivery is gated twice. A candidate must have a priority strictly above the programmable current-task priority, and strictly above the highest priority already in service. This allows nested service in priority order. When two candidates share a priority, the lower-indexed source wins. A global configuration register holds a mode bit and a self-clearing soft-reset bit. With the mode bit clear, arbitration is bypassed and the interrupt output follows source 0 directly.

The register map uses word addresses: 0x00 is the global configuration, 0x01 the task priority, 0x02 the acknowledge register (read), 0x03 end of interrupt (write), and 0x10+i the configuration word of source i. Reads are combinational on the address. Side effects of an acknowledge read take place at the clock edge where the read strobe is high.

Top module: `prio_vec_irq_ctrl`

## Requirements
- R1: After the synchronous reset, every source word reads 0x8000_0000 (mask set), the task priority reads 0xF, the global configuration reads 0 (pass-through mode, reset bit clear), and the acknowledge register reads 0xFF.
- R2: A source word holds the mask in bit 31, the read-only activity flag in bit 30, the polarity in bit 23 (1 = active high / rising edge), the sense in bit 22 (0 = edge, 1 = level), the priority in bits 19:16 and the vector in bits 7:0. All other bits read 0, and writes to bit 30 have no effect.
- R3: An edge-sensitive source becomes pending on an active edge of its input, and its activity flag reads 1 while it is pending or in service. An acknowledge that selects it clears its pending flag.
- R4: A level-sensitive source is pending while its input is at the active level, and it stays pending after it is acknowledged.
- R5: In mixed mode, irq_out is high exactly when an unmasked, pending source that is not in service has a priority strictly greater than both the task priority and every in-service priority.
- R6: An acknowledge read returns, in bits 7:0, the vector of the qualifying source with the highest priority, with ties won by the lower source index, and moves that source into service.
- R7: With no qualifying source, an acknowledge read returns 0xFF and changes no state.
- R8: Any write to the end-of-interrupt register ends service of the in-service source with the highest priority, so nested interrupts retire in order.
- R9: The task priority register keeps bits 3:0 of a write. Its reset value 0xF blocks every source.
- R10: Writing bit 31 of the global configuration sets every mask, clears all pending and in-service state, and returns the task priority to 0xF. Bit 31 reads 1 for exactly one cycle after the write and then reads 0. Bit 29 takes the written mode.
- R11: With bit 29 of the global configuration at 0 (pass-through), irq_out equals irq_in[0] and an acknowledge read returns 0xFF with no effect.
- R12: A masked source is never delivered but still captures requests (its activity flag reads 1). Clearing its mask makes a request captured earlier deliverable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Raw interrupt request per source |
| reg_addr | input | ADDR_W | Word address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; enables acknowledge side effects |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the controller with NUM_SRC set to 6 and ADDR_W kept at 6. With six sources, every subset of pending requests is reachable by a random 6-bit pulse mask, and the tie-break scan crosses a non-power-of-two source count. The random rounds draw priorities over the full 4-bit range with a low task priority. This makes priority ties, nested acknowledges and spurious reads frequent, and each result is compared with a bench model of pending and in-service state.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    localparam int DATA_W = 32;
    localparam int PRIO_W = 4;
    localparam int VEC_W  = 8;

    localparam logic [PRIO_W-1:0] PRIO_TOP     = '1;
    localparam logic [VEC_W-1:0]  VEC_SPURIOUS = 8'hFF;

    // source word field positions
    localparam int BIT_MASK  = 31;
    localparam int BIT_ACT   = 30;
    localparam int BIT_POL   = 23;
    localparam int BIT_SENSE = 22;
    localparam int PRIO_LSB  = 16;
    localparam int VEC_LSB   = 0;

    // global configuration fields
    localparam int GCFG_RST  = 31;
    localparam int GCFG_MODE = 29;

    // word addresses
    localparam int ADR_GCFG     = 0;
    localparam int ADR_TASK     = 1;
    localparam int ADR_ACK      = 2;
    localparam int ADR_EOI      = 3;
    localparam int ADR_SRC_BASE = 16;

    typedef enum logic {
        SENSE_EDGE  = 1'b0,
        SENSE_LEVEL = 1'b1
    } sense_e;

    typedef struct packed {
        logic              mask;
        logic              pol;
        sense_e            sense;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } src_cfg_t;

    localparam src_cfg_t SRC_CFG_RST = '{
        mask:  1'b1,
        pol:   1'b0,
        sense: SENSE_EDGE,
        prio:  '0,
        vec:   '0
    };

    function automatic src_cfg_t unpack_src(input logic [DATA_W-1:0] w);
        src_cfg_t c;
        c.mask  = w[BIT_MASK];
        c.pol   = w[BIT_POL];
        c.sense = sense_e'(w[BIT_SENSE]);
        c.prio  = w[PRIO_LSB +: PRIO_W];
        c.vec   = w[VEC_LSB +: VEC_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_src(input src_cfg_t c, input logic act);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_MASK]             = c.mask;
        w[BIT_ACT]              = act;
        w[BIT_POL]              = c.pol;
        w[BIT_SENSE]            = c.sense;
        w[PRIO_LSB +: PRIO_W]   = c.prio;
        w[VEC_LSB +: VEC_W]     = c.vec;
        return w;
    endfunction

endpackage

// File: rtl/pvic_source.sv
module pvic_source
    import pvic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     cfg_we,
    input  src_cfg_t cfg_wval,
    input  logic     raw_in,
    input  logic     take,
    input  logic     retire,
    output src_cfg_t cfg,
    output logic     pend,
    output logic     in_svc
);

    logic s_now, s_prev;
    logic act_now, act_prev, edge_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_now  <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s_now  <= raw_in;
            s_prev <= s_now;
        end
    end

    assign act_now  = (s_now  == cfg.pol);
    assign act_prev = (s_prev == cfg.pol);
    assign edge_hit = act_now & ~act_prev;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cfg <= SRC_CFG_RST;
        end else if (cfg_we) begin
            cfg <= cfg_wval;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend <= 1'b0;
        end else if (cfg.sense == SENSE_LEVEL) begin
            pend <= act_now;
        end else begin
            pend <= (pend & ~take) | edge_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            in_svc <= 1'b0;
        end else if (take) begin
            in_svc <= 1'b1;
        end else if (retire) begin
            in_svc <= 1'b0;
        end
    end

    // R3
    edge_ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !clr && !cfg_we && cfg.sense == SENSE_EDGE && !edge_hit) |=> !pend);

    // R6
    take_enters_service_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !clr) |=> in_svc);

endmodule

// File: rtl/pvic_pick.sv
module pvic_pick
    import pvic_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             cand,
    input  logic [N-1:0][PRIO_W-1:0] prio,
    output logic                     found,
    output logic [IDX_W-1:0]         idx,
    output logic [PRIO_W-1:0]        best
);

    // scan from the top index down; ">=" lets a lower index take a tie
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i] && (!found || prio[i] >= best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = prio[i];
            end
        end
    end

endmodule

// File: rtl/prio_vec_irq_ctrl.sv
module prio_vec_irq_ctrl
    import pvic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               reg_rd,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_out
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    // ---------------- decode ----------------
    logic hit_gcfg, hit_task, hit_ack, hit_eoi;
    logic wr_gcfg, wr_task, ack_rd, eoi_wr;
    logic [NUM_SRC-1:0] src_hit;

    assign hit_gcfg = (reg_addr == ADDR_W'(ADR_GCFG));
    assign hit_task = (reg_addr == ADDR_W'(ADR_TASK));
    assign hit_ack  = (reg_addr == ADDR_W'(ADR_ACK));
    assign hit_eoi  = (reg_addr == ADDR_W'(ADR_EOI));

    assign wr_gcfg = reg_wr & hit_gcfg;
    assign wr_task = reg_wr & hit_task;
    assign eoi_wr  = reg_wr & hit_eoi;
    assign ack_rd  = reg_rd & hit_ack;

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

    src_cfg_t wr_cfg;
    assign wr_cfg = unpack_src(reg_wdata);

    // ---------------- global state ----------------
    logic              mode_q;
    logic              swrst_q;
    logic [PRIO_W-1:0] task_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            swrst_q <= 1'b0;
        end else if (wr_gcfg) begin
            mode_q  <= reg_wdata[GCFG_MODE];
            swrst_q <= reg_wdata[GCFG_RST];
        end else begin
            swrst_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || swrst_q) begin
            task_q <= PRIO_TOP;
        end else if (wr_task) begin
            task_q <= reg_wdata[PRIO_W-1:0];
        end
    end

    // ---------------- sources ----------------
    src_cfg_t                      cfg_a [NUM_SRC];
    logic [NUM_SRC-1:0]            pend_v, in_svc_v, take_v, retire_v, cand_v;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_v;

    logic              req_found, svc_found, fire, take_any;
    logic [IDX_W-1:0]  req_idx, svc_idx;
    logic [PRIO_W-1:0] req_prio, svc_prio;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_hit[g]  = (reg_addr == ADDR_W'(ADR_SRC_BASE + g));
        assign take_v[g]   = take_any & (req_idx == IDX_W'(g));
        assign retire_v[g] = eoi_wr & svc_found & (svc_idx == IDX_W'(g));
        assign prio_v[g]   = cfg_a[g].prio;
        assign cand_v[g]   = pend_v[g] & ~cfg_a[g].mask & ~in_svc_v[g];

        pvic_source u_src (
            .clk      (clk),
            .rst      (rst),
            .clr      (swrst_q),
            .cfg_we   (reg_wr & src_hit[g]),
            .cfg_wval (wr_cfg),
            .raw_in   (irq_in[g]),
            .take     (take_v[g]),
            .retire   (retire_v[g]),
            .cfg      (cfg_a[g]),
            .pend     (pend_v[g]),
            .in_svc   (in_svc_v[g])
        );
    end

    // ---------------- arbitration ----------------
    pvic_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_req_pick (
        .cand  (cand_v),
        .prio  (prio_v),
        .found (req_found),
        .idx   (req_idx),
        .best  (req_prio)
    );

    pvic_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_svc_pick (
        .cand  (in_svc_v),
        .prio  (prio_v),
        .found (svc_found),
        .idx   (svc_idx),
        .best  (svc_prio)
    );

    assign fire     = mode_q & req_found & (req_prio > task_q)
                    & (!svc_found || req_prio > svc_prio);
    assign take_any = ack_rd & fire;
    assign irq_out  = mode_q ? fire : irq_in[0];

    // ---------------- read mux ----------------
    always_comb begin
        reg_rdata = '0;
        if (hit_gcfg) begin
            reg_rdata[GCFG_RST]  = swrst_q;
            reg_rdata[GCFG_MODE] = mode_q;
        end else if (hit_task) begin
            reg_rdata[PRIO_W-1:0] = task_q;
        end else if (hit_ack) begin
            reg_rdata[VEC_W-1:0] = fire ? cfg_a[req_idx].vec : VEC_SPURIOUS;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_hit[i]) begin
                reg_rdata = pack_src(cfg_a[i], pend_v[i] | in_svc_v[i]);
            end
        end
    end

    // ---------------- assertions ----------------
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (task_q == PRIO_TOP && !mode_q && !swrst_q && in_svc_v == '0));

    // R10
    soft_reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        swrst_q |=> (task_q == PRIO_TOP && in_svc_v == '0 && pend_v == '0));

    // R7
    spurious_value_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !take_any) |-> (reg_rdata == DATA_W'(VEC_SPURIOUS)));

    // R7
    spurious_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !take_any && !eoi_wr && !swrst_q) |=> $stable(in_svc_v));

    // R8
    eoi_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && svc_found && !swrst_q) |=> !in_svc_v[$past(svc_idx)]);

    // R5
    nesting_order_chk: assert property (@(posedge clk) disable iff (rst)
        take_any |-> (req_prio > task_q && (!svc_found || req_prio > svc_prio)));

endmodule

// File: tb/prio_vec_irq_ctrl_tb.sv
module prio_vec_irq_ctrl_tb;

    localparam int N  = 6;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_rd = 1'b0;
    logic [31:0]   reg_rdata;
    logic          irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    prio_vec_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    localparam int A_GCFG = 0, A_TASK = 1, A_ACK = 2, A_EOI = 3, A_SRC = 16;

    // bench model
    logic [3:0] m_prio [N];
    logic [7:0] m_vec  [N];
    logic [N-1:0] m_mask, m_pend, m_svc;
    logic [3:0] m_task;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] src_word(input logic mask, input logic pol,
                                             input logic sense, input logic [3:0] prio,
                                             input logic [7:0] vec);
        return {mask, 1'b0, 6'b0, pol, sense, 2'b0, prio, 8'b0, vec};
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(a); reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input int a, output logic [31:0] d);
        reg_addr = AW'(a);
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk); irq_in = irq_in | m;
        @(negedge clk); irq_in = irq_in & ~m;
        repeat (3) @(negedge clk);
    endtask

    // model arbitration: highest priority, ties to lower index
    task automatic m_eval(output logic fire, output int widx, output int sidx);
        logic rf, sf;
        logic [3:0] rb, sb;
        rf = 0; sf = 0; rb = 0; sb = 0; widx = 0; sidx = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_pend[i] && !m_mask[i] && !m_svc[i] && (!rf || m_prio[i] >= rb)) begin
                rf = 1; rb = m_prio[i]; widx = i;
            end
            if (m_svc[i] && (!sf || m_prio[i] >= sb)) begin
                sf = 1; sb = m_prio[i]; sidx = i;
            end
        end
        fire = rf && rb > m_task && (!sf || rb > sb);
        if (!sf) sidx = -1;
    endtask

    logic [31:0] d;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // ---- reset state ----
        peek(A_SRC + 0, d); check("R1 src0 after reset", d, 32'h8000_0000);
        peek(A_SRC + 5, d); check("R1 src5 after reset", d, 32'h8000_0000);
        peek(A_TASK, d);    check("R1 task after reset", d, 32'h0000_000F);
        peek(A_GCFG, d);    check("R1 gcfg after reset", d, 32'h0);
        rd(A_ACK, d);       check("R1 ack after reset", d, 32'hFF);

        // ---- pass-through ----
        irq_in[0] = 1'b1; #1;
        check("R11 passthrough high", {31'b0, irq_out}, 32'h1);
        rd(A_ACK, d); check("R11 passthrough ack spurious", d, 32'hFF);
        irq_in[0] = 1'b0; #1;
        check("R11 passthrough low", {31'b0, irq_out}, 32'h0);

        wr(A_GCFG, 32'h2000_0000);
        peek(A_GCFG, d); check("R10 mode bit set", d, 32'h2000_0000);
        peek(A_TASK, d); check("R9 task unchanged by mode", d, 32'hF);

        // ---- field layout ----
        wr(A_SRC + 5, 32'hFFFF_FFFF);
        peek(A_SRC + 5, d); check("R2 layout all ones", d, 32'h80CF_00FF);
        wr(A_SRC + 5, src_word(1, 1, 0, 0, 0));

        // ---- masked capture, tie break, spurious ----
        wr(A_TASK, 32'h0);
        wr(A_SRC + 1, src_word(0, 1, 0, 4'd5, 8'h21));
        wr(A_SRC + 2, src_word(0, 1, 0, 4'd5, 8'h22));
        wr(A_SRC + 3, src_word(1, 1, 0, 4'd9, 8'h23));
        pulse(6'b001110);
        peek(A_SRC + 3, d); check("R12 masked source captures", d, 32'hC089_0023);
        #1 check("R5 irq with pending", {31'b0, irq_out}, 32'h1);
        rd(A_ACK, d); check("R6 tie to lower index", d, 32'h21);
        #1 check("R5 equal prio blocked by service", {31'b0, irq_out}, 32'h0);
        rd(A_ACK, d); check("R7 spurious while blocked", d, 32'hFF);
        peek(A_SRC + 1, d); check("R3 activity in service", d, 32'h4085_0021);
        wr(A_EOI, 32'h0);
        peek(A_SRC + 1, d); check("R3 edge cleared after service", d, 32'h0085_0021);
        #1 check("R5 irq after eoi", {31'b0, irq_out}, 32'h1);
        rd(A_ACK, d); check("R6 second equal source", d, 32'h22);
        wr(A_EOI, 32'h0);

        // ---- nesting ----
        pulse(6'b000010);
        rd(A_ACK, d); check("R6 low source first", d, 32'h21);
        wr(A_SRC + 3, src_word(0, 1, 0, 4'd9, 8'h23));
        #1 check("R12 unmask delivers captured", {31'b0, irq_out}, 32'h1);
        rd(A_ACK, d); check("R8 nested higher source", d, 32'h23);
        wr(A_EOI, 32'h0);
        peek(A_SRC + 3, d); check("R8 eoi retires top", d, 32'h0089_0023);
        peek(A_SRC + 1, d); check("R8 lower stays in service", d, 32'h4085_0021);
        wr(A_EOI, 32'h0);
        peek(A_SRC + 1, d); check("R8 second eoi", d, 32'h0085_0021);

        // ---- level and task priority ----
        wr(A_SRC + 4, src_word(0, 1, 1, 4'd7, 8'h44));
        wr(A_TASK, 32'h7);
        @(negedge clk); irq_in[4] = 1'b1;
        repeat (3) @(negedge clk);
        #1 check("R9 equal task prio blocks", {31'b0, irq_out}, 32'h0);
        wr(A_TASK, 32'hF6);
        peek(A_TASK, d); check("R9 task keeps low bits", d, 32'h6);
        #1 check("R9 lower task prio allows", {31'b0, irq_out}, 32'h1);
        rd(A_ACK, d); check("R4 level ack", d, 32'h44);
        wr(A_EOI, 32'h0);
        #1 check("R4 level still pending", {31'b0, irq_out}, 32'h1);
        rd(A_ACK, d); check("R4 level ack again", d, 32'h44);
        wr(A_EOI, 32'h0);
        irq_in[4] = 1'b0;
        repeat (3) @(negedge clk);
        #1 check("R4 level released", {31'b0, irq_out}, 32'h0);
        peek(A_SRC + 4, d); check("R4 activity drops", d, 32'h00C7_0044);

        // ---- soft reset ----
        wr(A_GCFG, 32'hA000_0000);
        peek(A_GCFG, d); check("R10 reset bit visible", d, 32'hA000_0000);
        @(negedge clk);
        peek(A_GCFG, d); check("R10 reset bit self clears", d, 32'h2000_0000);
        peek(A_SRC + 1, d); check("R10 masks set", d, 32'h8000_0000);
        peek(A_TASK, d); check("R10 task back to F", d, 32'hF);

        // ---- random rounds ----
        for (int r = 0; r < 200; r++) begin
            logic [N-1:0] p;
            wr(A_GCFG, 32'hA000_0000);
            m_task = 4'($urandom_range(0, 3));
            wr(A_TASK, {28'b0, m_task});
            for (int i = 0; i < N; i++) begin
                m_prio[i] = 4'($urandom_range(0, 15));
                m_vec[i]  = 8'h40 + 8'(i);
                m_mask[i] = ($urandom % 4) == 0;
                wr(A_SRC + i, src_word(m_mask[i], 1, 0, m_prio[i], m_vec[i]));
            end
            m_svc = '0;
            p = N'($urandom);
            m_pend = p;
            pulse(p);
            for (int k = 0; k < 8; k++) begin
                logic f;
                int wi, si;
                m_eval(f, wi, si);
                #1 check("R5 random irq", {31'b0, irq_out}, {31'b0, f});
                if (($urandom % 3) != 0) begin
                    rd(A_ACK, d);
                    check("R6 random ack", d, f ? {24'b0, m_vec[wi]} : 32'hFF);
                    if (f) begin
                        m_svc[wi]  = 1'b1;
                        m_pend[wi] = 1'b0;
                    end
                end else begin
                    wr(A_EOI, 32'h0);
                    if (si >= 0) m_svc[si] = 1'b0;
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule